// File: doc/BRIEF.md
# Vector Widening Multiply-Long Unit

This block executes integer multiply-long operations on one fixed-width slice of a vector register. It takes a 32-bit instruction word and two source slices. From each source it picks the narrow elements at the even positions ("bottom") or at the odd positions ("top"). It multiplies the picked elements pairwise and writes results that are twice the source element width. Three kinds of multiply are supported: unsigned, signed, and signed with saturating doubling. A built-in decoder extracts the operation, the element size and the register numbers, and it raises a flag for any word it does not handle.

All lanes are computed in parallel in one combinational pass. The result is held in a single output register. Both the input and the output use valid/ready handshakes.

- The unit accepts a word when `in_valid` and `in_ready` are both high at a clock edge.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, every output holds still and no new word is accepted.

Top module: `vmul_unit`

## Requirements
- R1: A word is recognised only when bits [31:24] = 8'h45, bit [21] = 0 and bits [15:13] = 3'b011. The register fields are taken from the word as dest = [4:0], first source = [9:5] and second source = [20:16], and appear on `out_rd`, `out_rn` and `out_rm`. A word that fails the match raises `out_unsup`.
- R2: Bits [12:10] pick the operation: 000 is saturating-doubling bottom, 001 is saturating-doubling top, 100 is signed bottom, 101 is signed top, 110 is unsigned bottom and 111 is unsigned top. The values 010 and 011 raise `out_unsup`.
- R3: Bits [23:22] give the result element width: 01 gives 16 bits, 10 gives 32 bits and 11 gives 64 bits. The value 00 raises `out_unsup`.
- R4: Result lane j is formed from narrow element 2j of both sources for the bottom forms, and from narrow element 2j+1 of both sources for the top forms. Narrow element k occupies bits [k*N +: N], where N is half the result width. Result lane j occupies bits [j*2N +: 2N].
- R5: The signed forms sign-extend both narrow operands and the unsigned forms zero-extend them. The exact double-width product is then written.
- R6: The saturating form writes twice the signed product. If doubling exceeds the most positive result value, the lane is clamped to that value. `out_sat` is high with a result in which any lane clamped.
- R7: `sat_sticky` goes high at the edge that accepts a word whose result clamps. After that it stays high until reset.
- R8: A word accepted at edge t is presented with `out_valid` high after edge t. `in_ready` = !out_valid || out_ready. While the output is stalled, `out_data` and the fields beside it hold.
- R9: An unsupported word still produces an output beat. That beat has `out_we` low and `out_data` all zero, so the destination is left unchanged. A supported word produces a beat with `out_we` high and `out_unsup` low.
- R10: During reset `out_valid` and `sat_sticky` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word and sources are valid |
| in_ready | output | 1 | Unit can accept a word this cycle |
| in_instr | input | 32 | Instruction word |
| in_zn | input | VLEN | First source slice |
| in_zm | input | VLEN | Second source slice |
| out_valid | output | 1 | Result beat is valid |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | VLEN | Wide results, lane j at bits [j*W +: W] |
| out_rd | output | 5 | Destination register number |
| out_rn | output | 5 | First source register number |
| out_rm | output | 5 | Second source register number |
| out_we | output | 1 | Write the destination |
| out_unsup | output | 1 | Word not handled by this unit |
| out_sat | output | 1 | Some lane of this beat clamped |
| sat_sticky | output | 1 | Some accepted word has clamped since reset |

## Verification
Each of the six operations is driven at all three sizes with several operand patterns:

- Random operands whose even and odd elements differ catch a wrong bottom/top pick.
- All-ones operands separate sign extension from zero extension.
- Most-negative values in both operands give the only clamping case and show the doubled product differing from the plain one.
- A mix of most-negative and most-positive values probes the largest non-clamping magnitudes.

Malformed words, the polynomial codes and size 00 confirm the unsupported path. A phase with a randomly toggling `out_ready` tests stall hold and back-pressure.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  typedef enum logic [1:0] {
    MK_SATDBL   = 2'd0,
    MK_SIGNED   = 2'd1,
    MK_UNSIGNED = 2'd2
  } mul_kind_e;

  typedef struct packed {
    logic      legal;
    mul_kind_e kind;
    logic      odd;
    logic [1:0] esz;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
  } vmul_dec_t;

  localparam logic [7:0] MAJOR_OP = 8'h45;
  localparam logic [2:0] GROUP_OP = 3'b011;
  localparam int         NSIZE    = 3;
endpackage

// File: rtl/vmul_decode.sv
module vmul_decode
  import vmul_pkg::*;
(
  input  logic [31:0] instr,
  output vmul_dec_t   dec
);
  logic [2:0] opc;
  logic       match;
  logic       opc_ok;

  always_comb begin
    opc    = instr[12:10];
    match  = (instr[31:24] == MAJOR_OP) && !instr[21] && (instr[15:13] == GROUP_OP);
    // codes 010/011 belong to the polynomial form, not handled here
    opc_ok = opc[2] || !opc[1];
    dec.esz   = instr[23:22];
    dec.rd    = instr[4:0];
    dec.rn    = instr[9:5];
    dec.rm    = instr[20:16];
    dec.odd   = opc[0];
    dec.legal = match && opc_ok && (instr[23:22] != 2'b00);
    if (!opc[2])     dec.kind = MK_SATDBL;
    else if (!opc[1]) dec.kind = MK_SIGNED;
    else             dec.kind = MK_UNSIGNED;
  end
endmodule

// File: rtl/vmul_lane.sv
module vmul_lane #(
  parameter int NW = 8
) (
  input  logic [NW-1:0]   a,
  input  logic [NW-1:0]   b,
  input  logic            sgn,
  input  logic            dbl,
  output logic [2*NW-1:0] res,
  output logic            sat
);
  localparam int WW = 2 * NW;

  logic signed [NW:0]   ax, bx;
  logic signed [WW-1:0] ae, be, prod;

  always_comb begin
    ax   = {sgn & a[NW-1], a};
    bx   = {sgn & b[NW-1], b};
    ae   = WW'(ax);
    be   = WW'(bx);
    prod = ae * be;
    // doubling overflows exactly when the top two product bits differ
    sat  = dbl && (prod[WW-1] ^ prod[WW-2]);
    if (sat)      res = {1'b0, {(WW-1){1'b1}}};
    else if (dbl) res = {prod[WW-2:0], 1'b0};
    else          res = prod;
  end
endmodule

// File: rtl/vmul_bank.sv
module vmul_bank #(
  parameter int VLEN = 128,
  parameter int NW   = 8
) (
  input  logic [VLEN-1:0] zn,
  input  logic [VLEN-1:0] zm,
  input  logic            odd,
  input  logic            sgn,
  input  logic            dbl,
  output logic [VLEN-1:0] res,
  output logic            sat
);
  localparam int WW = 2 * NW;
  localparam int NL = VLEN / WW;

  logic [NL-1:0] lane_sat;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [NW-1:0] a_pick, b_pick;
    assign a_pick = odd ? zn[(2*l+1)*NW +: NW] : zn[(2*l)*NW +: NW];
    assign b_pick = odd ? zm[(2*l+1)*NW +: NW] : zm[(2*l)*NW +: NW];
    vmul_lane #(.NW(NW)) u_lane (
      .a   (a_pick),
      .b   (b_pick),
      .sgn (sgn),
      .dbl (dbl),
      .res (res[l*WW +: WW]),
      .sat (lane_sat[l])
    );
  end

  assign sat = |lane_sat;
endmodule

// File: rtl/vmul_unit.sv
module vmul_unit
  import vmul_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [VLEN-1:0] in_zn,
  input  logic [VLEN-1:0] in_zm,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] out_data,
  output logic [4:0]      out_rd,
  output logic [4:0]      out_rn,
  output logic [4:0]      out_rm,
  output logic            out_we,
  output logic            out_unsup,
  output logic            out_sat,
  output logic            sat_sticky
);
  vmul_dec_t       dec;
  logic            op_sgn, op_dbl, accept;
  logic [VLEN-1:0] bank_res [NSIZE];
  logic            bank_sat [NSIZE];
  logic [VLEN-1:0] res_sel;
  logic            sat_sel;

  vmul_decode u_dec (.instr(in_instr), .dec(dec));

  assign op_sgn   = (dec.kind != MK_UNSIGNED);
  assign op_dbl   = (dec.kind == MK_SATDBL);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    vmul_bank #(.VLEN(VLEN), .NW(8 << g)) u_bank (
      .zn  (in_zn),
      .zm  (in_zm),
      .odd (dec.odd),
      .sgn (op_sgn),
      .dbl (op_dbl),
      .res (bank_res[g]),
      .sat (bank_sat[g])
    );
  end

  always_comb begin
    res_sel = '0;
    sat_sel = 1'b0;
    for (int g = 0; g < NSIZE; g++) begin
      if (dec.legal && (dec.esz == 2'(g + 1))) begin
        res_sel = bank_res[g];
        sat_sel = bank_sat[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_rd     <= '0;
      out_rn     <= '0;
      out_rm     <= '0;
      out_we     <= 1'b0;
      out_unsup  <= 1'b0;
      out_sat    <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= res_sel;
        out_rd    <= dec.rd;
        out_rn    <= dec.rn;
        out_rm    <= dec.rm;
        out_we    <= dec.legal;
        out_unsup <= !dec.legal;
        out_sat   <= sat_sel;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && sat_sel) sat_sticky <= 1'b1;
    end
  end
endmodule

// File: rtl/vmul_unit_chk.sv
module vmul_unit_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [31:0]     in_instr,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] out_data,
  input logic [4:0]      out_rd,
  input logic            out_we,
  input logic            out_unsup,
  input logic            out_sat,
  input logic            sat_sticky
);
  assert_accept_to_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_rd));

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_poly_unsup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_instr[12:11] == 2'b01) |=> out_unsup && !out_we);

  assert_size_zero_unsup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_instr[23:22] == 2'b00) |=> out_unsup && !out_we);

  assert_unsup_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unsup |-> (out_data == '0));

  assert_sat_only_dbl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_instr[12] |=> !out_sat);

  assert_sticky_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sat |-> sat_sticky);

  assert_sticky_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sat_sticky));
endmodule

bind vmul_unit vmul_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_instr   (in_instr),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_rd     (out_rd),
  .out_we     (out_we),
  .out_unsup  (out_unsup),
  .out_sat    (out_sat),
  .sat_sticky (sat_sticky)
);

// File: tb/sim_vmul_unit.sv
module sim_vmul_unit;
  localparam int VLEN = 128;

  logic            clk = 1'b0;
  logic            rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [31:0]     in_instr;
  logic [VLEN-1:0] in_zn, in_zm, out_data;
  logic [4:0]      out_rd, out_rn, out_rm;
  logic            out_we, out_unsup, out_sat, sat_sticky;

  always #10 clk = ~clk;

  vmul_unit #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_zn(in_zn), .in_zm(in_zm),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm), .out_we(out_we),
    .out_unsup(out_unsup), .out_sat(out_sat), .sat_sticky(sat_sticky)
  );

  typedef struct {
    logic [VLEN-1:0] data;
    logic [4:0]      rd, rn, rm;
    logic            we, unsup, sat;
    string           tag;
  } exp_t;

  exp_t            q[$];
  int              n_chk = 0, n_bad = 0, cycles = 0;
  logic            exp_sticky = 1'b0, stall_seen = 1'b0, last_acc = 1'b0, rand_bp = 1'b0;
  logic [VLEN-1:0] stall_data;
  string           cur_tag = "R1";

  task automatic check(string req, string what, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [1:0] sz, logic [2:0] opc, logic [4:0] rd,
                                     logic [4:0] rn, logic [4:0] rm);
    return {8'h45, sz, 1'b0, rm, 3'b011, opc, rn, rd};
  endfunction

  function automatic exp_t model(logic [31:0] w, logic [VLEN-1:0] a, logic [VLEN-1:0] b, string tag);
    exp_t e;
    logic [2:0] opc = w[12:10];
    int sz = int'(w[23:22]);
    logic ok;
    e.rd = w[4:0]; e.rn = w[9:5]; e.rm = w[20:16];
    e.data = '0; e.sat = 1'b0; e.tag = tag;
    ok = (w[31:24] == 8'h45) && !w[21] && (w[15:13] == 3'b011) &&
         (opc != 3'b010) && (opc != 3'b011) && (sz != 0);
    e.we = ok; e.unsup = !ok;
    if (ok) begin
      int ww = 8 << sz;
      int nw = ww / 2;
      int top = int'(opc[0]);
      logic sgn = (opc[2:1] != 2'b11);
      logic dbl = !opc[2];
      for (int j = 0; j < VLEN / ww; j++) begin
        logic signed [130:0] x, y, p, mx;
        x = '0; y = '0;
        for (int k = 0; k < nw; k++) begin
          x[k] = a[(2*j+top)*nw + k];
          y[k] = b[(2*j+top)*nw + k];
        end
        if (sgn && x[nw-1]) x = x - (131'sd1 <<< nw);
        if (sgn && y[nw-1]) y = y - (131'sd1 <<< nw);
        p = x * y;
        if (dbl) p = p * 2;
        mx = (131'sd1 <<< (ww - 1)) - 1;
        if (dbl && p > mx) begin p = mx; e.sat = 1'b1; end
        for (int k = 0; k < ww; k++) e.data[j*ww + k] = p[k];
      end
    end
    return e;
  endfunction

  // evaluate the cycle between edges, then move to the next falling edge
  task automatic cyc();
    exp_t e;
    #1;
    check("R7", "sat_sticky", VLEN'(sat_sticky), VLEN'(exp_sticky));
    check("R8", "out_valid", VLEN'(out_valid), VLEN'(q.size() != 0));
    if (stall_seen) check("R8", "stall hold", out_data, stall_data);
    if (out_valid && out_ready && q.size() > 0) begin
      e = q.pop_front();
      check(e.tag, "out_data", out_data, e.data);
      check("R1", "out_rd", VLEN'(out_rd), VLEN'(e.rd));
      check("R1", "out_rn/out_rm", VLEN'({out_rn, out_rm}), VLEN'({e.rn, e.rm}));
      check("R9", "out_we", VLEN'(out_we), VLEN'(e.we));
      check("R9", "out_unsup", VLEN'(out_unsup), VLEN'(e.unsup));
      check("R6", "out_sat", VLEN'(out_sat), VLEN'(e.sat));
    end
    stall_seen = out_valid && !out_ready;
    stall_data = out_data;
    last_acc   = in_valid && in_ready;
    if (last_acc) begin
      e = model(in_instr, in_zn, in_zm, cur_tag);
      q.push_back(e);
      exp_sticky = exp_sticky | e.sat;
    end
    @(negedge clk);
    if (rand_bp) out_ready = 1'($urandom_range(0, 1));
  endtask

  task automatic send(logic [31:0] w, logic [VLEN-1:0] a, logic [VLEN-1:0] b, string tag);
    in_valid = 1'b1; in_instr = w; in_zn = a; in_zm = b; cur_tag = tag;
    cyc();
    while (!last_acc) cyc();
    in_valid = 1'b0;
  endtask

  function automatic logic [VLEN-1:0] rep(logic [63:0] v, int nw);
    logic [VLEN-1:0] r = '0;
    for (int i = 0; i < VLEN / nw; i++)
      for (int k = 0; k < nw; k++) r[i*nw + k] = v[k];
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] ops [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_instr = '0; in_zn = '0; in_zm = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R10", "reset out_valid", VLEN'(out_valid), '0);
    check("R10", "reset sat_sticky", VLEN'(sat_sticky), '0);
    @(negedge clk);
    rst_n = 1'b1;

    // unsupported encodings first, sticky must stay low (R1 R2 R3 R9)
    send(mk(2'b01, 3'b010, 5'd3, 5'd4, 5'd5), rnd(), rnd(), "R2");
    send(mk(2'b10, 3'b011, 5'd6, 5'd7, 5'd8), rnd(), rnd(), "R2");
    send(mk(2'b00, 3'b100, 5'd9, 5'd1, 5'd2), rnd(), rnd(), "R3");
    send(mk(2'b10, 3'b100, 5'd1, 5'd2, 5'd3) ^ 32'h0100_0000, rnd(), rnd(), "R1");
    send(mk(2'b10, 3'b100, 5'd1, 5'd2, 5'd3) | 32'h0020_0000, rnd(), rnd(), "R1");
    send(mk(2'b11, 3'b110, 5'd1, 5'd2, 5'd3) ^ 32'h0000_4000, rnd(), rnd(), "R1");

    // every size, every operation, corner and random operands (R3 R4 R5 R6)
    for (int s = 1; s <= 3; s++) begin
      for (int o = 0; o < 6; o++) begin
        int nw = 4 << s;
        logic [63:0] mn = 64'd1 << (nw - 1);
        logic [63:0] mx = mn - 64'd1;
        logic [63:0] ones = (mn << 1) - 64'd1;
        string tg = ops[o][2] ? "R4 R5 R3" : "R4 R6 R3";
        logic [31:0] w = mk(2'(s), ops[o], 5'(o + s), 5'(2 * o), 5'(31 - o));
        for (int r = 0; r < 3; r++) send(w, rnd(), rnd(), tg);
        send(w, rep(ones, nw), rep(ones, nw), tg);
        send(w, rep(mn, nw), rep(mn, nw), tg);
        send(w, rep(mx, nw), rep(mx, nw), tg);
        send(w, rep(mn, nw), rep(mx, nw), tg);
        send(w, rep(mn, 2 * nw), rep(mn, 2 * nw), tg);
        send(w, rep(mn << nw, 2 * nw), rep(mn << nw, 2 * nw), tg);
      end
    end

    // back-pressure with a toggling consumer (R8)
    rand_bp = 1'b1;
    for (int i = 0; i < 60; i++) begin
      int s = 1 + (i % 3);
      send(mk(2'(s), ops[i % 6], 5'(i), 5'(i + 1), 5'(i + 2)), rnd(), rnd(), "R8");
      if (i % 4 == 0) cyc();
    end
    rand_bp = 1'b0;
    out_ready = 1'b1;
    repeat (4) cyc();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule